// File: doc/BRIEF.md
# Activate Spacing and Four-Activate Window Checker

This block sits beside a memory controller, or on a monitor path, and passively watches a decoded SDRAM command stream. It sees one command slot per clock and checks two activate-timing rules for each rank.

The first rule is the row-to-row minimum. Two activates in the same scope must be at least a configured number of cycles apart. The second rule is the rolling four-activate window. A rank may not see a fifth activate while the fourth-previous activate is still inside the configured window.

Both minimums are given in clock cycles on configuration inputs, so the same block covers any speed grade or page size. A mode input picks the scope of the row-to-row rule: the whole rank, or a single bank group within the rank. Every activate is stamped from a free-running cycle counter. The block keeps the last stamp for each rank and for each bank group, and a four-deep ring of stamps for each rank. A violation raises a one-cycle pulse for its rule, together with a tag that encodes which rule or rules fired.

Top module: `act_spacing_chk`

## Requirements
- R1: After a synchronous reset, `viol_rrd` and `viol_faw` are low and `viol_tag` is 0. All activate history is forgotten, so the first activate after reset is never flagged.
- R2: A slot counts as an activate only when `cmd_valid` is 1 and `cmd_code` equals 4'h3. Any other slot raises no flag and leaves the history unchanged.
- R3: An activate raises `viol_rrd` one cycle after it is sampled when its cycle gap to the previous activate in its scope is strictly less than `cfg_rrd`. A gap exactly equal to `cfg_rrd` is legal, and `cfg_rrd` = 0 never flags.
- R4: With `ddr4_mode` = 1, the row-to-row scope is the same rank and the same bank group.
- R5: With `ddr4_mode` = 0, the row-to-row scope is the whole rank, and `cmd_bg` has no effect.
- R6: Ranks are tracked independently. An activate to one rank never counts toward a rule in another rank.
- R7: An activate raises `viol_faw` one cycle after it is sampled when its cycle gap to the fourth-previous activate in the same rank is strictly less than `cfg_faw`. A gap exactly equal to `cfg_faw` is legal.
- R8: The first four activates to a rank after reset never raise `viol_faw`.
- R9: An activate that raises a flag is recorded in the history like any other activate.
- R10: `viol_tag` is updated in the same cycle as the pulses. It reads 0 for no violation, 1 for a row-to-row violation only, 2 for a window violation only, and 3 for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command slot holds a command |
| cmd_code | input | CMD_W (4) | Decoded command code; 4'h3 is activate |
| cmd_rank | input | RK_W (1) | Rank index of the command |
| cmd_bg | input | BG_W (2) | Bank-group index of the command |
| ddr4_mode | input | 1 | 1: row-to-row rule per bank group; 0: per rank |
| cfg_rrd | input | CFG_W (8) | Row-to-row minimum, in cycles |
| cfg_faw | input | CFG_W (8) | Four-activate window, in cycles |
| viol_rrd | output | 1 | One-cycle pulse on a row-to-row violation |
| viol_faw | output | 1 | One-cycle pulse on a window violation |
| viol_tag | output | 2 | Which rule fired (0 none, 1 row-to-row, 2 window, 3 both) |

## Verification
The bench aims at the inclusive boundaries: a gap exactly equal to `cfg_rrd` or to `cfg_faw` must pass. A design that compared with less-or-equal would flag these legal activates. It also checks that the first four activates after reset never trip the window, since a design that treated empty ring entries as stamp zero would report false window violations early on. Further cases cover mode scope (bank group ignored in rank mode, bank group honoured in per-group mode) and rank isolation. Finally, it checks that a flagged activate still enters the history; a design that dropped it would miss the next violation or compare against a stale entry.

// File: rtl/act_chk_pkg.sv
package act_chk_pkg;
  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_RRD  = 2'd1,
    TAG_FAW  = 2'd2,
    TAG_BOTH = 2'd3
  } viol_tag_e;
endpackage

// File: rtl/act_cycle_timer.sv
// Free-running cycle stamp shared by both trackers.
module act_cycle_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + TS_W'(1);
  end
endmodule

// File: rtl/act_rrd_tracker.sv
// Last-activate stamps per rank and per (rank, bank group); row-to-row compare.
module act_rrd_tracker #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BG    = 4,
  parameter int TS_W      = 16,
  parameter int CFG_W     = 8,
  parameter int RK_W      = 1,
  parameter int BG_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic [RK_W-1:0]  rank,
  input  logic [BG_W-1:0]  bg,
  input  logic             ddr4_mode,
  input  logic [TS_W-1:0]  now,
  input  logic [CFG_W-1:0] cfg_rrd,
  output logic             hit
);
  localparam int SLOTS = NUM_RANKS * NUM_BG;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [TS_W-1:0]      rank_ts [NUM_RANKS];
  logic [TS_W-1:0]      grp_ts  [SLOTS];
  logic [NUM_RANKS-1:0] rank_vld;
  logic [SLOTS-1:0]     grp_vld;

  logic [IDX_W-1:0] idx;
  logic [TS_W-1:0]  ref_ts;
  logic             ref_vld;
  logic [TS_W-1:0]  gap;

  always_comb begin
    idx     = IDX_W'(rank) * IDX_W'(NUM_BG) + IDX_W'(bg);
    ref_ts  = ddr4_mode ? grp_ts[idx]  : rank_ts[rank];
    ref_vld = ddr4_mode ? grp_vld[idx] : rank_vld[rank];
    gap     = now - ref_ts;
    hit     = act && ref_vld && (gap < TS_W'(cfg_rrd));
  end

  // Stamp storage: plain write port, no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (act) begin
      rank_ts[rank] <= now;
      grp_ts[idx]   <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rank_vld <= '0;
      grp_vld  <= '0;
    end else if (act) begin
      rank_vld[rank] <= 1'b1;
      grp_vld[idx]   <= 1'b1;
    end
  end
endmodule

// File: rtl/act_faw_window.sv
// Per-rank ring of the last WIN_DEPTH activate stamps; window compare.
module act_faw_window #(
  parameter int NUM_RANKS = 2,
  parameter int WIN_DEPTH = 4,
  parameter int TS_W      = 16,
  parameter int CFG_W     = 8,
  parameter int RK_W      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic [RK_W-1:0]  rank,
  input  logic [TS_W-1:0]  now,
  input  logic [CFG_W-1:0] cfg_faw,
  output logic             hit
);
  localparam int PTR_W   = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
  localparam int ENTRIES = NUM_RANKS * WIN_DEPTH;
  localparam int AD_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TS_W-1:0]  hist [ENTRIES];
  logic [PTR_W-1:0] ptr_q [NUM_RANKS];
  logic [NUM_RANKS-1:0] full_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic             sel;
    logic [PTR_W-1:0] ptr_r;
    logic             full_r;
    logic             wrap;
    assign sel  = act && (rank == RK_W'(r));
    assign wrap = (ptr_r == PTR_W'(WIN_DEPTH - 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_r  <= '0;
        full_r <= 1'b0;
      end else if (sel) begin
        ptr_r <= wrap ? '0 : ptr_r + PTR_W'(1);
        if (wrap) full_r <= 1'b1;
      end
    end
    assign ptr_q[r]  = ptr_r;
    assign full_q[r] = full_r;
  end

  logic [PTR_W-1:0] ptr_sel;
  logic [AD_W-1:0]  addr;
  logic [TS_W-1:0]  gap;

  always_comb begin
    ptr_sel = ptr_q[rank];
    addr    = AD_W'(rank) * AD_W'(WIN_DEPTH) + AD_W'(ptr_sel);
    // Slot at the pointer is the oldest once the ring has filled.
    gap     = now - hist[addr];
    hit     = act && full_q[rank] && (gap < TS_W'(cfg_faw));
  end

  always_ff @(posedge clk) begin
    if (act) hist[addr] <= now;
  end
endmodule

// File: rtl/act_spacing_chk.sv
module act_spacing_chk #(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BG    = 4,
  parameter int WIN_DEPTH = 4,
  parameter int CMD_W     = 4,
  parameter int TS_W      = 16,
  parameter int CFG_W     = 8,
  parameter int RK_W      = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  parameter int BG_W      = (NUM_BG > 1) ? $clog2(NUM_BG) : 1,
  parameter logic [CMD_W-1:0] ACT_CODE = CMD_W'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [RK_W-1:0]  cmd_rank,
  input  logic [BG_W-1:0]  cmd_bg,
  input  logic             ddr4_mode,
  input  logic [CFG_W-1:0] cfg_rrd,
  input  logic [CFG_W-1:0] cfg_faw,
  output logic             viol_rrd,
  output logic             viol_faw,
  output logic [1:0]       viol_tag
);
  import act_chk_pkg::*;

  logic            act;
  logic [TS_W-1:0] now;
  logic            rrd_hit;
  logic            faw_hit;
  viol_tag_e       tag_d;

  assign act = cmd_valid && (cmd_code == ACT_CODE);

  act_cycle_timer #(.TS_W(TS_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  act_rrd_tracker #(
    .NUM_RANKS(NUM_RANKS), .NUM_BG(NUM_BG), .TS_W(TS_W),
    .CFG_W(CFG_W), .RK_W(RK_W), .BG_W(BG_W)
  ) u_rrd (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .rank      (cmd_rank),
    .bg        (cmd_bg),
    .ddr4_mode (ddr4_mode),
    .now       (now),
    .cfg_rrd   (cfg_rrd),
    .hit       (rrd_hit)
  );

  act_faw_window #(
    .NUM_RANKS(NUM_RANKS), .WIN_DEPTH(WIN_DEPTH), .TS_W(TS_W),
    .CFG_W(CFG_W), .RK_W(RK_W)
  ) u_faw (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .rank    (cmd_rank),
    .now     (now),
    .cfg_faw (cfg_faw),
    .hit     (faw_hit)
  );

  always_comb begin
    case ({faw_hit, rrd_hit})
      2'b01:   tag_d = TAG_RRD;
      2'b10:   tag_d = TAG_FAW;
      2'b11:   tag_d = TAG_BOTH;
      default: tag_d = TAG_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_rrd <= 1'b0;
      viol_faw <= 1'b0;
      viol_tag <= TAG_NONE;
    end else begin
      viol_rrd <= rrd_hit;
      viol_faw <= faw_hit;
      viol_tag <= tag_d;
    end
  end
endmodule

// File: rtl/act_spacing_chk_sva.sv
module act_spacing_chk_sva #(
  parameter int CMD_W = 4,
  parameter int CFG_W = 8,
  parameter int RK_W  = 1,
  parameter int BG_W  = 2,
  parameter logic [CMD_W-1:0] ACT_CODE = CMD_W'(3)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic [RK_W-1:0]  cmd_rank,
  input logic [BG_W-1:0]  cmd_bg,
  input logic             ddr4_mode,
  input logic [CFG_W-1:0] cfg_rrd,
  input logic [CFG_W-1:0] cfg_faw,
  input logic             viol_rrd,
  input logic             viol_faw,
  input logic [1:0]       viol_tag
);
  logic            is_act;
  logic [2:0]      acts_seen;
  logic            prev_act;
  logic [RK_W-1:0] prev_rank;

  assign is_act = cmd_valid && (cmd_code == ACT_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      acts_seen <= '0;
      prev_act  <= 1'b0;
      prev_rank <= '0;
    end else begin
      if (is_act && acts_seen != 3'd4) acts_seen <= acts_seen + 3'd1;
      prev_act  <= is_act;
      prev_rank <= cmd_rank;
    end
  end

  // R2
  no_stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !is_act |=> (!viol_rrd && !viol_faw));

  // R10
  tag_match_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_tag[0] == viol_rrd) && (viol_tag[1] == viol_faw));

  // R8
  early_window_chk: assert property (@(posedge clk) disable iff (rst)
    (is_act && acts_seen < 3'd4) |=> !viol_faw);

  // R5
  rank_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (is_act && !ddr4_mode && cfg_rrd > CFG_W'(1) && prev_act && cmd_rank == prev_rank) |=> viol_rrd);

  // R3
  rrd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (is_act && cfg_rrd == '0) |=> !viol_rrd);
endmodule

bind act_spacing_chk act_spacing_chk_sva #(
  .CMD_W(CMD_W), .CFG_W(CFG_W), .RK_W(RK_W), .BG_W(BG_W), .ACT_CODE(ACT_CODE)
) u_sva (.*);

// File: tb/act_spacing_chk_test.sv
`timescale 1ns/1ps
module act_spacing_chk_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       cmd_rank = 1'b0;
  logic [1:0] cmd_bg = 2'd0;
  logic       ddr4_mode = 1'b1;
  logic [7:0] cfg_rrd = 8'd4;
  logic [7:0] cfg_faw = 8'd16;
  logic       viol_rrd, viol_faw;
  logic [1:0] viol_tag;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  act_spacing_chk uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_rank(cmd_rank), .cmd_bg(cmd_bg), .ddr4_mode(ddr4_mode),
    .cfg_rrd(cfg_rrd), .cfg_faw(cfg_faw),
    .viol_rrd(viol_rrd), .viol_faw(viol_faw), .viol_tag(viol_tag)
  );

  localparam logic [3:0] ACT = 4'h3;
  localparam logic [3:0] RD  = 4'h5;

  // {valid, code, rank, bg, exp_rrd, exp_faw}; ddr4_mode=1, rrd=4, faw=16
  localparam int NV = 21;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, ACT, 1'b0, 2'd0, 1'b0, 1'b0}, // 0  first activate
    {1'b1, ACT, 1'b0, 2'd1, 1'b0, 1'b0}, // 1  other group R4
    {1'b1, ACT, 1'b0, 2'd0, 1'b1, 1'b0}, // 2  gap 2 same group R3
    {1'b0, ACT, 1'b0, 2'd0, 1'b0, 1'b0}, // 3  not valid R2
    {1'b1, RD,  1'b0, 2'd0, 1'b0, 1'b0}, // 4  read R2
    {1'b1, ACT, 1'b1, 2'd0, 1'b0, 1'b0}, // 5  other rank R6
    {1'b1, ACT, 1'b0, 2'd0, 1'b0, 1'b0}, // 6  gap 4 equals min R3
    {1'b1, ACT, 1'b0, 2'd2, 1'b0, 1'b1}, // 7  fifth, gap 7 R7
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 8
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 9
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 10
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 11
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 12
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 13
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 14
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 15
    {1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0}, // 16
    {1'b1, ACT, 1'b0, 2'd3, 1'b0, 1'b0}, // 17 window gap 16 exact R7
    {1'b1, ACT, 1'b0, 2'd3, 1'b1, 1'b0}, // 18 rrd only R9
    {1'b1, ACT, 1'b0, 2'd1, 1'b0, 1'b1}, // 19 window only R9
    {1'b1, ACT, 1'b0, 2'd1, 1'b1, 1'b1}  // 20 both R10
  };

  task automatic check(input string what, input int act_v, input int exp_v);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act_v, exp_v);
    end
  endtask

  // Called at a negedge: drive one slot, wait one cycle, compare outputs.
  task automatic step(input logic v, input logic [3:0] code, input logic rk,
                      input logic [1:0] bg, input logic er, input logic ef,
                      input string what);
    cmd_valid = v; cmd_code = code; cmd_rank = rk; cmd_bg = bg;
    @(negedge clk);
    check({what, " rrd"}, int'(viol_rrd), int'(er));
    check({what, " faw"}, int'(viol_faw), int'(ef));
    check({what, " tag (R10)"}, int'(viol_tag), int'({ef, er}));
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0; cmd_code = 4'h0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 reset rrd", int'(viol_rrd), 0);
    check("R1 reset faw", int'(viol_faw), 0);
    check("R1 reset tag", int'(viol_tag), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8:5], VEC[i][4], VEC[i][3:2], VEC[i][1], VEC[i][0],
           $sformatf("vector row %0d (R2 R3 R4 R6 R7 R9)", i));
    end

    // R1: history cleared by reset
    do_reset();
    check("R1 post-reset rrd", int'(viol_rrd), 0);
    check("R1 post-reset tag", int'(viol_tag), 0);
    step(1'b1, ACT, 1'b0, 2'd1, 1'b0, 1'b0, "R1 first act after reset");
    step(1'b1, ACT, 1'b0, 2'd1, 1'b1, 1'b0, "R3 back-to-back after reset");

    // R5 / R6: rank-wide scope
    do_reset();
    ddr4_mode = 1'b0;
    step(1'b1, ACT, 1'b0, 2'd0, 1'b0, 1'b0, "R5 first");
    step(1'b1, ACT, 1'b0, 2'd2, 1'b1, 1'b0, "R5 group ignored");
    step(1'b1, ACT, 1'b1, 2'd2, 1'b0, 1'b0, "R6 other rank");
    step(1'b1, ACT, 1'b0, 2'd1, 1'b1, 1'b0, "R5 gap 2");
    step(1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, "R2 idle");
    step(1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, "R2 idle");
    step(1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 1'b0, "R2 idle");
    step(1'b1, ACT, 1'b0, 2'd3, 1'b0, 1'b0, "R3 rank gap equals min");

    // R8 / R9: first four free, fifth and sixth flagged; rrd 0 never flags
    do_reset();
    ddr4_mode = 1'b1;
    cfg_rrd = 8'd0;
    cfg_faw = 8'd200;
    step(1'b1, ACT, 1'b1, 2'd0, 1'b0, 1'b0, "R8 act 1");
    step(1'b1, ACT, 1'b1, 2'd1, 1'b0, 1'b0, "R8 act 2");
    step(1'b1, ACT, 1'b1, 2'd2, 1'b0, 1'b0, "R8 act 3");
    step(1'b1, ACT, 1'b1, 2'd3, 1'b0, 1'b0, "R8 act 4");
    step(1'b1, ACT, 1'b1, 2'd0, 1'b0, 1'b1, "R7 act 5 rrd zero R3");
    step(1'b1, ACT, 1'b1, 2'd0, 1'b0, 1'b1, "R9 act 6 after flag");

    finish_run();
  end
endmodule